// File: doc/BRIEF.md
# Local Memory Read Steering Unit

This block sits beside a processor core's load and instruction-fetch path and decides, for every read, which on-core source returns the data. The read address is compared at once against two programmable regions, one backed by an on-core SRAM and one by an on-core ROM. The result of a cache lookup for the same read arrives in the same cycle. A fixed priority picks exactly one source. A region wins over the cache, the SRAM region wins over the ROM region, and when nothing hits the read is handed to system memory. The block also stops the cache from allocating any line whose data came from a region.

Software programs each region through one configuration word. That word sets a base address, a size code, a valid bit and two mask bits, one for instruction fetches and one for data reads. The region array's enable is raised only when the region is valid and not masked for that kind of access. This keeps unused arrays idle. Out of reset both regions are invalid, so reads are served by the cache or by system memory.

The source select and the region enables are combinational in the cycle of the read. The request to the external memory interface is registered and appears one cycle after an all-miss read, together with the captured address and access type.

Top module: `lmem_read_steer`

## Requirements
- R1: After reset both regions are invalid. A read then selects the cache when `cache_hit` is 1, and selects external memory otherwise.
- R2: When a read hits the SRAM region, `src_sel` is 4'b0001 (SRAM), whatever the ROM region and `cache_hit` say.
- R3: When a read misses the SRAM region but hits the ROM region, `src_sel` is 4'b0010 (ROM), whatever `cache_hit` says.
- R4: When both regions miss and `cache_hit` is 1, `src_sel` is 4'b0100 (cache).
- R5: When both regions and the cache miss, `src_sel` is 4'b1000. In the next cycle `ext_req` is 1 for one cycle, with `ext_addr` and `ext_ifetch` equal to that read's address and type. Back-to-back misses give back-to-back requests. A read that hits any source is followed by `ext_req` = 0.
- R6: `cache_alloc_inh` is 1 exactly when the selected source is SRAM or ROM.
- R7: A region hits only when its valid bit (config bit 0) is 1 and `rd_addr[31:L]` equals config bits [31:L]. Here L is the size code in config bits [7:3], raised to 8 when it is below 8. Base bits below L are ignored.
- R8: Config bit 1 masks the region for instruction fetches (`rd_ifetch` = 1), and config bit 2 masks it for data reads. A masked access never hits that region.
- R9: `sram_en` and `rom_en` are 1 only for a read whose region is valid and not masked for that access type. When `rd_valid` is 0, `src_sel`, both enables and `cache_alloc_inh` are 0.
- R10: A write with `cfg_we` = 1 loads `cfg_wdata` into the SRAM region (`cfg_sel` = 0) or the ROM region (`cfg_sel` = 1). The new value governs reads from the next cycle on. The other region is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_sel | input | 1 | Region chosen by the write: 0 SRAM, 1 ROM |
| cfg_wdata | input | 32 | Configuration word |
| rd_valid | input | 1 | A read is presented this cycle |
| rd_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data read |
| rd_addr | input | 32 | Read address |
| cache_hit | input | 1 | Cache lookup result for this read |
| sram_en | output | 1 | Enable for the SRAM array this read |
| rom_en | output | 1 | Enable for the ROM array this read |
| src_sel | output | 4 | One-hot source: bit0 SRAM, bit1 ROM, bit2 cache, bit3 external |
| cache_alloc_inh | output | 1 | Forbid cache allocation of this read's data |
| ext_req | output | 1 | External memory request, one cycle after an all-miss read |
| ext_addr | output | 32 | Address of the external request |
| ext_ifetch | output | 1 | Access type of the external request |

## Verification
The hardest case to reach is one where several sources hit at once, so that priority really decides the winner. The stimulus makes this happen by placing the SRAM region inside a larger ROM region and keeping `cache_hit` high. It then walks addresses across the SRAM edge and the ROM edge, and turns each mask bit on and off so that the same address alternates between sources by access type. Back-to-back all-miss reads with different addresses show that each registered external request carries its own read's address.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

  // Source index, also the bit position in the one-hot select
  typedef enum logic [1:0] {
    SRC_SRAM  = 2'd0,
    SRC_ROM   = 2'd1,
    SRC_CACHE = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;

  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned NUM_REGION = 2;
  localparam int unsigned REG_SRAM   = 0;
  localparam int unsigned REG_ROM    = 1;

  // Configuration word field positions
  localparam int unsigned F_VALID   = 0;
  localparam int unsigned F_MASK_IF = 1;
  localparam int unsigned F_MASK_DR = 2;
  localparam int unsigned F_SIZE_LO = 3;
  localparam int unsigned SIZE_W    = 5;
  localparam int unsigned BASE_LO   = F_SIZE_LO + SIZE_W;

  // Effective number of low address bits left out of the compare
  function automatic int unsigned eff_lg(input logic [SIZE_W-1:0] code);
    return (int'(code) < BASE_LO) ? BASE_LO : int'(code);
  endfunction

endpackage

// File: rtl/lmem_base_reg.sv
module lmem_base_reg
  import lmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              valid,
  output logic              mask_if,
  output logic              mask_dr,
  output logic [SIZE_W-1:0] size_code,
  output logic [ADDR_W-1:0] base
);

  localparam int unsigned BASE_W = ADDR_W - BASE_LO;

  logic              valid_q, mask_if_q, mask_dr_q;
  logic [SIZE_W-1:0] size_q;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      mask_if_q <= 1'b0;
      mask_dr_q <= 1'b0;
      size_q    <= '0;
      base_q    <= '0;
    end else if (wr_en) begin
      valid_q   <= wr_data[F_VALID];
      mask_if_q <= wr_data[F_MASK_IF];
      mask_dr_q <= wr_data[F_MASK_DR];
      size_q    <= wr_data[F_SIZE_LO +: SIZE_W];
      base_q    <= wr_data[ADDR_W-1:BASE_LO];
    end
  end

  assign valid     = valid_q;
  assign mask_if   = mask_if_q;
  assign mask_dr   = mask_dr_q;
  assign size_code = size_q;
  assign base      = {base_q, {BASE_LO{1'b0}}};

  // R10: without a write the region setting holds
  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(valid_q) && $stable(base_q) && $stable(size_q)
                && $stable(mask_if_q) && $stable(mask_dr_q)));

endmodule

// File: rtl/lmem_region_match.sv
module lmem_region_match
  import lmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_ifetch,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              valid,
  input  logic              mask_if,
  input  logic              mask_dr,
  input  logic [SIZE_W-1:0] size_code,
  input  logic [ADDR_W-1:0] base,
  output logic              region_en,
  output logic              region_hit
);

  // Compare mask: ones on the address bits that select the region
  function automatic logic [ADDR_W-1:0] upper_mask(input logic [SIZE_W-1:0] code);
    int unsigned lg;
    logic [ADDR_W-1:0] m;
    lg = eff_lg(code);
    m  = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < int'(lg)) m[i] = 1'b0;
    end
    return m;
  endfunction

  logic type_masked;
  logic addr_match;

  assign type_masked = rd_ifetch ? mask_if : mask_dr;
  assign addr_match  = ((rd_addr ^ base) & upper_mask(size_code)) == '0;
  assign region_en   = rd_valid && valid && !type_masked;
  assign region_hit  = region_en && addr_match;

  // R8: a hit needs the region enabled for this access type
  p_hit_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    region_hit |-> (valid && !type_masked && rd_valid));

  // R7: an invalid region never hits
  p_invalid_never_hits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !region_hit);

endmodule

// File: rtl/lmem_src_arbiter.sv
module lmem_src_arbiter
  import lmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_valid,
  input  logic               rd_ifetch,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               sram_hit,
  input  logic               rom_hit,
  input  logic               cache_hit,
  output logic [NUM_SRC-1:0] src_sel,
  output logic               alloc_inh,
  output logic               ext_req,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic               ext_ifetch
);

  // Lowest set bit wins: index order is the priority order
  function automatic logic [NUM_SRC-1:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [NUM_SRC-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] winner;
  logic               all_miss;

  always_comb begin
    cand           = '0;
    cand[SRC_SRAM] = sram_hit;
    cand[SRC_ROM]  = rom_hit;
    cand[SRC_CACHE]= cache_hit;
    cand[SRC_EXT]  = 1'b1;
  end

  assign winner    = first_set(cand);
  assign src_sel   = rd_valid ? winner : '0;
  assign all_miss  = rd_valid && !sram_hit && !rom_hit && !cache_hit;
  assign alloc_inh = src_sel[SRC_SRAM] | src_sel[SRC_ROM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_req    <= 1'b0;
      ext_addr   <= '0;
      ext_ifetch <= 1'b0;
    end else begin
      ext_req <= all_miss;
      if (all_miss) begin
        ext_addr   <= rd_addr;
        ext_ifetch <= rd_ifetch;
      end
    end
  end

  // R2: SRAM wins whenever it hits
  p_sram_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && sram_hit) |-> (src_sel == 4'b0001));

  // R3: ROM wins over the cache when SRAM misses
  p_rom_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !sram_hit && rom_hit) |-> (src_sel == 4'b0010));

  // R4: exactly one source for every read
  p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($countones(src_sel) == 1));

  // R5: an all-miss read becomes a request in the next cycle
  p_miss_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    all_miss |=> (ext_req && ext_addr == $past(rd_addr)
                  && ext_ifetch == $past(rd_ifetch)));

  // R5: no request without an all-miss read before it
  p_request_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> $past(all_miss));

  // R6: allocation is blocked only for region data
  p_inhibit_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_inh |-> (src_sel[SRC_SRAM] || src_sel[SRC_ROM]));

  // R9: nothing selected without a read
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (src_sel == '0 && !alloc_inh));

endmodule

// File: rtl/lmem_read_steer.sv
module lmem_read_steer
  import lmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               rd_valid,
  input  logic               rd_ifetch,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               cache_hit,
  output logic               sram_en,
  output logic               rom_en,
  output logic [NUM_SRC-1:0] src_sel,
  output logic               cache_alloc_inh,
  output logic               ext_req,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic               ext_ifetch
);

  logic [NUM_REGION-1:0] reg_wr;
  logic [NUM_REGION-1:0] reg_en;
  logic [NUM_REGION-1:0] reg_hit;

  for (genvar g = 0; g < NUM_REGION; g++) begin : g_region
    logic              valid, mask_if, mask_dr;
    logic [SIZE_W-1:0] size_code;
    logic [ADDR_W-1:0] base;

    assign reg_wr[g] = cfg_we && (int'(cfg_sel) == g);

    lmem_base_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr[g]),
      .wr_data   (cfg_wdata),
      .valid     (valid),
      .mask_if   (mask_if),
      .mask_dr   (mask_dr),
      .size_code (size_code),
      .base      (base)
    );

    lmem_region_match #(.ADDR_W(ADDR_W)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (rd_valid),
      .rd_ifetch  (rd_ifetch),
      .rd_addr    (rd_addr),
      .valid      (valid),
      .mask_if    (mask_if),
      .mask_dr    (mask_dr),
      .size_code  (size_code),
      .base       (base),
      .region_en  (reg_en[g]),
      .region_hit (reg_hit[g])
    );
  end

  assign sram_en = reg_en[REG_SRAM];
  assign rom_en  = reg_en[REG_ROM];

  lmem_src_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_ifetch  (rd_ifetch),
    .rd_addr    (rd_addr),
    .sram_hit   (reg_hit[REG_SRAM]),
    .rom_hit    (reg_hit[REG_ROM]),
    .cache_hit  (cache_hit),
    .src_sel    (src_sel),
    .alloc_inh  (cache_alloc_inh),
    .ext_req    (ext_req),
    .ext_addr   (ext_addr),
    .ext_ifetch (ext_ifetch)
  );

  // R10: a write touches only the chosen region
  p_single_region_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr));

endmodule

// File: tb/lmem_read_steer_tb.sv
module lmem_read_steer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ifetch = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        cache_hit = 1'b0;
  logic        sram_en, rom_en, cache_alloc_inh, ext_req, ext_ifetch;
  logic [3:0]  src_sel;
  logic [31:0] ext_addr;

  always #5 clk = ~clk;

  lmem_read_steer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_ifetch(rd_ifetch),
    .rd_addr(rd_addr), .cache_hit(cache_hit), .sram_en(sram_en),
    .rom_en(rom_en), .src_sel(src_sel), .cache_alloc_inh(cache_alloc_inh),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_ifetch(ext_ifetch)
  );

  typedef struct {
    logic [3:0]  sel;
    logic        inh, sen, ren, ext, ifetch;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] regs[2];
  int          n_chk = 0, n_fail = 0;
  bit          mon_on = 0, done = 0;
  bit          pend_ext = 0, pend_if = 0, prev_rd = 0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Model of a region from its configuration word
  function automatic bit m_en(logic [31:0] r, bit f);
    return r[0] && !(f ? r[1] : r[2]);
  endfunction

  function automatic bit m_hit(logic [31:0] r, logic [31:0] a, bit f);
    int lg;
    lg = (r[7:3] < 8) ? 8 : int'(r[7:3]);
    return m_en(r, f) && ((a >> lg) == (r >> lg));
  endfunction

  function automatic logic [31:0] mk(logic [31:0] b, int sz, bit mdr, bit mif, bit v);
    return (b & 32'hFFFF_FF00) | (32'(sz) << 3) | {29'd0, mdr, mif, v};
  endfunction

  task automatic cfg_write(input bit sel, input logic [31:0] d);
    @(posedge clk); #2;
    rd_valid = 0; cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 0;
    regs[sel] = d;
  endtask

  task automatic do_read(input string tag, input bit f, input logic [31:0] a, input bit c);
    exp_t e;
    bit sh, rh;
    @(posedge clk); #2;
    rd_valid = 1; rd_ifetch = f; rd_addr = a; cache_hit = c;
    sh = m_hit(regs[0], a, f);
    rh = m_hit(regs[1], a, f);
    e.sel = sh ? 4'b0001 : rh ? 4'b0010 : c ? 4'b0100 : 4'b1000;
    e.inh = sh || rh;
    e.sen = m_en(regs[0], f);
    e.ren = m_en(regs[1], f);
    e.ext = !sh && !rh && !c;
    e.ifetch = f; e.addr = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic [31:0] a);
    @(posedge clk); #2;
    rd_valid = 0; rd_addr = a; cache_hit = 1;
  endtask

  // Monitor: compares outputs against the queued expectations
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend_ext) begin
        chk(ext_req == 1'b1, "R5", "ext_req", 32'(ext_req), 32'd1);
        chk(ext_addr == pend_addr, "R5", "ext_addr", ext_addr, pend_addr);
        chk(ext_ifetch == pend_if, "R5", "ext_ifetch", 32'(ext_ifetch), 32'(pend_if));
      end else if (prev_rd) begin
        chk(ext_req == 1'b0, "R5", "ext_req after hit", 32'(ext_req), 32'd0);
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected read", 32'd0, 32'd1);
          pend_ext = 0;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(src_sel == e.sel, e.tag, "src_sel", 32'(src_sel), 32'(e.sel));
          chk(cache_alloc_inh == e.inh, "R6", "cache_alloc_inh",
              32'(cache_alloc_inh), 32'(e.inh));
          chk({sram_en, rom_en} == {e.sen, e.ren}, "R9", "sram_en/rom_en",
              32'({sram_en, rom_en}), 32'({e.sen, e.ren}));
          pend_ext = e.ext; pend_addr = e.addr; pend_if = e.ifetch;
        end
        prev_rd = 1;
      end else begin
        chk(src_sel == 4'd0 && !sram_en && !rom_en && !cache_alloc_inh, "R9",
            "idle outputs", 32'({src_sel, sram_en, rom_en, cache_alloc_inh}), 32'd0);
        pend_ext = 0; prev_rd = 0;
      end
    end
  end

  initial begin
    regs[0] = '0; regs[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(src_sel == 4'd0 && ext_req == 1'b0, "R1", "in reset",
        32'({src_sel, ext_req}), 32'd0);
    @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;

    // R1: regions invalid after reset
    do_read("R1", 0, 32'h2000_0100, 1);
    do_read("R1", 1, 32'h0000_0000, 0);
    idle(32'h0);

    // SRAM inside a larger ROM region
    cfg_write(0, mk(32'h2000_0000, 12, 0, 0, 1));
    cfg_write(1, mk(32'h2000_0000, 20, 0, 0, 1));
    do_read("R2", 0, 32'h2000_0100, 1);
    do_read("R2", 1, 32'h2000_0FFF, 1);
    do_read("R3", 0, 32'h2000_1000, 1);
    do_read("R3", 1, 32'h200F_FFFF, 0);
    do_read("R7", 0, 32'h2010_0000, 0);
    do_read("R4", 0, 32'h4000_0000, 1);
    // R5: back-to-back misses
    do_read("R5", 1, 32'h5000_0000, 0);
    do_read("R5", 0, 32'h5000_0004, 0);
    do_read("R4", 1, 32'h6000_0000, 1);
    idle(32'h2000_0100);
    idle(32'h2000_0100);

    // R8: fetch mask on SRAM, data mask on ROM
    cfg_write(0, mk(32'h2000_0000, 12, 0, 1, 1));
    do_read("R8", 1, 32'h2000_0100, 1);
    do_read("R8", 0, 32'h2000_0100, 1);
    cfg_write(1, mk(32'h2000_0000, 20, 1, 0, 1));
    do_read("R8", 0, 32'h2001_0000, 1);
    do_read("R8", 1, 32'h2001_0000, 0);
    do_read("R8", 1, 32'h2000_0100, 0);

    // R7: size code below the minimum and unaligned base
    cfg_write(0, mk(32'h3000_0000, 2, 0, 0, 1));
    do_read("R7", 0, 32'h3000_00FF, 0);
    do_read("R7", 0, 32'h3000_0100, 1);
    cfg_write(0, mk(32'h3000_0800, 12, 0, 0, 1));
    do_read("R7", 0, 32'h3000_0010, 0);
    do_read("R7", 1, 32'h3000_1000, 0);

    // R10: disabling ROM leaves SRAM as it was
    cfg_write(1, mk(32'h2000_0000, 20, 0, 0, 0));
    do_read("R10", 0, 32'h2001_0000, 0);
    do_read("R10", 0, 32'h3000_0FF0, 0);
    idle(32'h3000_0000);
    idle(32'h3000_0000);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9", "queue drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule